// File: doc/BRIEF.md
# Inter-Stage Register Readiness Tracker

This block sits beside a ring of execution stages. Each stage runs one window of instructions and keeps a private copy of the register file. A sequencer hands each new window to a free stage along with two 32-bit masks, which are known before any instruction of the window is fetched. The consume mask lists the registers whose values the window reads from older windows. The produce mask lists the registers whose final values the window passes on to younger windows. Dependencies inside a window are resolved by running its instructions in order, so the masks describe only traffic between stages.

The tracker records, for every stage and register, whether a consumed value is still missing. When a stage reports the final write of a register it produces, that readiness travels toward the younger stages. It stops at the first younger stage that also produces the same register, because that stage supplies the value to everything beyond it. The sequencer gives the ring position of the oldest window (the head). It also retires the head and discards mispredicted stages. The block reports one ready flag per register per stage.

Top module: `regmask_fwd`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every ready flag is 0.
- R2: After a stage is allocated, every register outside its consume mask reads ready. A consumed register that no older active stage produces also reads ready. Flags appear on the cycle after the allocation edge. Register r of stage s is bit s*NREG+r of `reg_ready`, and mask bit r is register r.
- R3: A consumed register reads not ready when the nearest older active stage that produces it has not yet reported its final write.
- R4: A consumed register reads ready at allocation when its nearest older producer has already reported its final write.
- R5: A final-write report from a stage makes that register ready, one cycle later, in every younger active stage up to and including the first younger stage that produces it. Ready flags never drop except on allocation, squash or retirement of that stage.
- R6: A forwarded write does not pass a younger stage that produces the same register. Stages beyond it keep waiting.
- R7: A write report for a register outside the writer's produce mask changes no ready flag.
- R8: A squashed stage reads all-zero on the next cycle and no longer counts as a producer.
- R9: Retiring the head stage clears all of that stage's flags on the next cycle.
- R10: An allocation sees a final-write report made in the same cycle by its nearest older producer, and marks that register ready.
- R11: Age order follows the ring from the head index, including across the wrap from the last stage index to stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_idx | input | IDX_W | Ring position of the oldest window |
| alloc_valid | input | 1 | Assign a new window to a stage |
| alloc_idx | input | IDX_W | Stage receiving the window |
| alloc_use | input | NREG | Consume mask of the new window |
| alloc_create | input | NREG | Produce mask of the new window |
| wr_valid | input | 1 | Final-write report |
| wr_idx | input | IDX_W | Stage making the report |
| wr_reg | input | REG_W | Register written |
| commit_valid | input | 1 | Retire the head stage |
| squash | input | NSTAGE | Per-stage discard |
| reg_ready | output | NSTAGE*NREG | Per-stage, per-register ready flags |

## Verification
The bench builds the block with four stages and 32 registers. With four stages, a three-stage chain of producers and consumers can be set up, and advancing the head twice pushes the youngest window across the index wrap. Each stage's ready word is predicted from the masks and write reports. The cases covered are: blocked forwarding, a non-producer write, squash, retirement, and an allocation in the same cycle as its producer's final write.

// File: rtl/regmask_fwd_pkg.sv
package regmask_fwd_pkg;
  // Age of stage s counted from the head along the ring.
  function automatic int unsigned ring_dist(int unsigned s, int unsigned h, int unsigned n);
    return (s >= h) ? (s - h) : (s + n - h);
  endfunction
  // Ring index offset by a signed step.
  function automatic int unsigned ring_step(int unsigned s, int d, int unsigned n);
    int t;
    t = int'(s) + d;
    if (t < 0) t = t + int'(n);
    if (t >= int'(n)) t = t - int'(n);
    return int'(t);
  endfunction
endpackage

// File: rtl/regmask_write_walk.sv
module regmask_write_walk
  import regmask_fwd_pkg::*;
#(
  parameter int NSTAGE = 4,
  parameter int NREG   = 32,
  localparam int IDX_W = (NSTAGE > 1) ? $clog2(NSTAGE) : 1,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [IDX_W-1:0]             head_idx,
  input  logic [NSTAGE-1:0]            live,
  input  logic [NSTAGE-1:0][NREG-1:0]  cre,
  input  logic                         wr_valid,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [REG_W-1:0]             wr_reg,
  output logic                         src_hit,
  output logic [NSTAGE-1:0]            fwd
);
  // Walk younger stages from the writer until a producer of the same
  // register, an idle stage, or the head closes the path.
  always_comb begin
    logic open;
    int unsigned s;
    src_hit = wr_valid && live[wr_idx] && cre[wr_idx][wr_reg];
    open    = src_hit;
    fwd     = '0;
    for (int d = 1; d < NSTAGE; d++) begin
      s = ring_step(int'(wr_idx), d, NSTAGE);
      if (s == int'(head_idx)) open = 1'b0;
      if (open && live[s]) begin
        fwd[s] = 1'b1;
        if (cre[s][wr_reg]) open = 1'b0;
      end else begin
        open = 1'b0;
      end
    end
  end
endmodule

// File: rtl/regmask_alloc_scan.sv
module regmask_alloc_scan
  import regmask_fwd_pkg::*;
#(
  parameter int NSTAGE = 4,
  parameter int NREG   = 32,
  localparam int IDX_W = (NSTAGE > 1) ? $clog2(NSTAGE) : 1
) (
  input  logic [IDX_W-1:0]             head_idx,
  input  logic [IDX_W-1:0]             alloc_idx,
  input  logic [NSTAGE-1:0]            older_live,
  input  logic [NSTAGE-1:0][NREG-1:0]  cre,
  input  logic [NSTAGE-1:0][NREG-1:0]  outstanding,
  input  logic [NREG-1:0]              use_mask,
  output logic [NREG-1:0]              pend
);
  // Nearest older stage first: a producer claims the register, and it
  // is pending only while that producer still owes its final write.
  always_comb begin
    logic [NREG-1:0] open_regs;
    int unsigned s;
    int unsigned my_age;
    open_regs = use_mask;
    pend      = '0;
    my_age    = ring_dist(int'(alloc_idx), int'(head_idx), NSTAGE);
    for (int d = 1; d < NSTAGE; d++) begin
      s = ring_step(int'(alloc_idx), -d, NSTAGE);
      if (older_live[s] && ring_dist(s, int'(head_idx), NSTAGE) < my_age) begin
        pend      = pend | (open_regs & cre[s] & outstanding[s]);
        open_regs = open_regs & ~cre[s];
      end
    end
  end
endmodule

// File: rtl/regmask_fwd.sv
module regmask_fwd #(
  parameter int NSTAGE = 4,
  parameter int NREG   = 32,
  localparam int IDX_W = (NSTAGE > 1) ? $clog2(NSTAGE) : 1,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IDX_W-1:0]         head_idx,
  input  logic                     alloc_valid,
  input  logic [IDX_W-1:0]         alloc_idx,
  input  logic [NREG-1:0]          alloc_use,
  input  logic [NREG-1:0]          alloc_create,
  input  logic                     wr_valid,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [REG_W-1:0]         wr_reg,
  input  logic                     commit_valid,
  input  logic [NSTAGE-1:0]        squash,
  output logic [NSTAGE*NREG-1:0]   reg_ready
);
  logic [NSTAGE-1:0]            live_q, live_n, kill, older_live;
  logic [NSTAGE-1:0][NREG-1:0]  cre_q, cre_n;
  logic [NSTAGE-1:0][NREG-1:0]  owe_q, owe_n;
  logic [NSTAGE-1:0][NREG-1:0]  pend_q, pend_n;
  logic [NSTAGE-1:0][NREG-1:0]  ready_q, ready_n;
  logic [NSTAGE-1:0]            fwd;
  logic                         src_hit;
  logic [NREG-1:0]              new_pend;
  logic [NREG-1:0]              wr_bit;

  assign wr_bit = NREG'(1) << wr_reg;

  always_comb begin
    for (int s = 0; s < NSTAGE; s++)
      kill[s] = squash[s] || (commit_valid && head_idx == IDX_W'(s));
  end
  assign older_live = live_q & ~kill;

  regmask_write_walk #(.NSTAGE(NSTAGE), .NREG(NREG)) u_walk (
    .head_idx (head_idx),
    .live     (older_live),
    .cre      (cre_q),
    .wr_valid (wr_valid),
    .wr_idx   (wr_idx),
    .wr_reg   (wr_reg),
    .src_hit  (src_hit),
    .fwd      (fwd)
  );

  // Outstanding-producer state after this cycle's write report.
  logic [NSTAGE-1:0][NREG-1:0] owe_after;
  always_comb begin
    for (int s = 0; s < NSTAGE; s++) begin
      owe_after[s] = owe_q[s];
      if (src_hit && wr_idx == IDX_W'(s)) owe_after[s] = owe_q[s] & ~wr_bit;
    end
  end

  regmask_alloc_scan #(.NSTAGE(NSTAGE), .NREG(NREG)) u_scan (
    .head_idx    (head_idx),
    .alloc_idx   (alloc_idx),
    .older_live  (older_live),
    .cre         (cre_q),
    .outstanding (owe_after),
    .use_mask    (alloc_use),
    .pend        (new_pend)
  );

  always_comb begin
    for (int s = 0; s < NSTAGE; s++) begin
      if (alloc_valid && alloc_idx == IDX_W'(s)) begin
        live_n[s] = 1'b1;
        cre_n[s]  = alloc_create;
        owe_n[s]  = alloc_create;
        pend_n[s] = new_pend;
      end else if (kill[s]) begin
        live_n[s] = 1'b0;
        cre_n[s]  = '0;
        owe_n[s]  = '0;
        pend_n[s] = '0;
      end else begin
        live_n[s] = live_q[s];
        cre_n[s]  = cre_q[s];
        owe_n[s]  = owe_after[s];
        pend_n[s] = fwd[s] ? (pend_q[s] & ~wr_bit) : pend_q[s];
      end
      ready_n[s] = live_n[s] ? ~pend_n[s] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      cre_q   <= '0;
      owe_q   <= '0;
      pend_q  <= '0;
      ready_q <= '0;
    end else begin
      live_q  <= live_n;
      cre_q   <= cre_n;
      owe_q   <= owe_n;
      pend_q  <= pend_n;
      ready_q <= ready_n;
    end
  end

  assign reg_ready = ready_q;

  // R1: flags are clear on the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> reg_ready == '0);

  for (genvar g = 0; g < NSTAGE; g++) begin : g_chk
    // R8: squash empties the stage
    a_r8_squash_clears: assert property (@(posedge clk) disable iff (rst)
      squash[g] && !(alloc_valid && alloc_idx == IDX_W'(g)) |=> ready_q[g] == '0);
    // R9: retirement of the head empties it
    a_r9_commit_clears: assert property (@(posedge clk) disable iff (rst)
      commit_valid && head_idx == IDX_W'(g) && !squash[g] &&
      !(alloc_valid && alloc_idx == IDX_W'(g)) |=> ready_q[g] == '0);
    // R5: flags only rise while the stage holds its window
    a_r5_ready_monotonic: assert property (@(posedge clk) disable iff (rst)
      !(alloc_valid && alloc_idx == IDX_W'(g)) && !squash[g] &&
      !(commit_valid && head_idx == IDX_W'(g))
      |=> ($past(ready_q[g]) & ~ready_q[g]) == '0);
    // R2: registers not consumed are ready right after allocation
    a_r2_unused_ready: assert property (@(posedge clk) disable iff (rst)
      alloc_valid && alloc_idx == IDX_W'(g)
      |=> (ready_q[g] | $past(alloc_use)) == {NREG{1'b1}});
  end
endmodule

// File: tb/regmask_fwd_bench.sv
module regmask_fwd_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSTAGE = 4;
  localparam int NREG   = 32;
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  head_idx = '0;
  logic        alloc_valid = 1'b0;
  logic [1:0]  alloc_idx = '0;
  logic [31:0] alloc_use = '0, alloc_create = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [4:0]  wr_reg = '0;
  logic        commit_valid = 1'b0;
  logic [3:0]  squash = '0;
  logic [NSTAGE*NREG-1:0] reg_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  int          q_stage[$];
  logic [31:0] q_mask[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  regmask_fwd #(.NSTAGE(NSTAGE), .NREG(NREG)) u_regmask_fwd (
    .clk(clk), .rst(rst), .head_idx(head_idx),
    .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .alloc_use(alloc_use), .alloc_create(alloc_create),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_reg(wr_reg),
    .commit_valid(commit_valid), .squash(squash), .reg_ready(reg_ready)
  );

  function automatic logic [31:0] b(int r);
    return 32'h1 << r;
  endfunction

  task automatic expect_stage(int s, logic [31:0] m, string tag);
    q_stage.push_back(s); q_mask.push_back(m); q_tag.push_back(tag);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    alloc_valid = 0; wr_valid = 0; commit_valid = 0; squash = '0;
  endtask

  task automatic do_alloc(int s, logic [31:0] u, logic [31:0] c);
    alloc_valid = 1; alloc_idx = 2'(s); alloc_use = u; alloc_create = c;
  endtask

  task automatic do_write(int s, int r);
    wr_valid = 1; wr_idx = 2'(s); wr_reg = 5'(r);
  endtask

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (q_tag.size() > 0) begin
      int s; logic [31:0] m; string t; logic [31:0] act;
      s = q_stage.pop_front(); m = q_mask.pop_front(); t = q_tag.pop_front();
      act = reg_ready[s*NREG +: NREG];
      checks++;
      if (act !== m) begin
        errors++;
        $display("FAIL %s stage %0d actual=%h expected=%h", t, s, act, m);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; repeat (3) tick();
    for (int s = 0; s < NSTAGE; s++) expect_stage(s, '0, "R1");
    @(negedge clk); #1;
    rst = 0;
    tick();
    for (int s = 0; s < NSTAGE; s++) expect_stage(s, '0, "R1");
    head_idx = 0;
    do_alloc(0, b(1)|b(2), b(3)|b(5)); tick();
    expect_stage(0, ALL, "R2");
    do_alloc(1, b(3)|b(4), b(5)); tick();
    expect_stage(1, ~b(3), "R3");
    do_alloc(2, b(5)|b(3), 32'h0); tick();
    expect_stage(2, ~(b(3)|b(5)), "R3");
    do_write(1, 3); tick();
    expect_stage(1, ~b(3), "R7");
    expect_stage(2, ~(b(3)|b(5)), "R7");
    do_write(0, 5); tick();
    expect_stage(1, ~b(3), "R6");
    expect_stage(2, ~(b(3)|b(5)), "R6");
    do_write(0, 3); tick();
    expect_stage(1, ALL, "R5");
    expect_stage(2, ~b(5), "R5");
    do_write(1, 5); tick();
    expect_stage(2, ALL, "R5");
    do_alloc(3, b(3)|b(5)|b(9), 32'h0); tick();
    expect_stage(3, ALL, "R4");
    commit_valid = 1; tick();
    expect_stage(0, '0, "R9");
    head_idx = 1;
    squash = 4'b1100; tick();
    expect_stage(2, '0, "R8");
    expect_stage(3, '0, "R8");
    do_alloc(2, 32'h0, b(8)); tick();
    expect_stage(2, ALL, "R2");
    do_alloc(3, b(8), b(8)|b(10)); tick();
    expect_stage(3, ~b(8), "R3");
    do_alloc(0, b(8)|b(10), 32'h0); tick();
    expect_stage(0, ~(b(8)|b(10)), "R11");
    do_write(2, 8); tick();
    expect_stage(3, ALL, "R5");
    expect_stage(0, ~(b(8)|b(10)), "R6");
    do_write(3, 8); tick();
    expect_stage(0, ~b(10), "R11");
    commit_valid = 1; tick();
    expect_stage(1, '0, "R9");
    head_idx = 2;
    do_alloc(1, b(10), 32'h0); do_write(3, 10); tick();
    expect_stage(1, ALL, "R10");
    expect_stage(0, ALL, "R11");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule